// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Entry Locking

This block keeps a small fully associative translation buffer. Every slot holds a tag and a translation entry. Bit 63 of an entry marks it as valid, and bit 6 marks it as locked. All traffic goes through one register-style command port. Each command carries a space code, a write strobe, an address and write data. Read results come back on a registered read-data bus.

Software first loads the tag-staging register with the tag it wants to install. It then issues one of two writes:

- An insert write, which lets the block pick a slot.
- A slot write, which names the slot directly.

Either write stores the staged tag beside the written entry. A lookup read searches the slots for a valid entry whose tag equals the address value and returns the tag it finds. The insert search fills a free slot first. If there is no free slot, it evicts an unlocked one. Locked entries are therefore never evicted by an insert. When nothing can be evicted, the insert is dropped and an overflow pulse is raised.

Top module: `tlb_lock_cam`

## Requirements
- R1: After reset, every slot is invalid, the tag-staging register is zero, `ovf` is 0, and `rdata` is 0.
- R2: A register write (space 0) with `addr[6:3]` equal to 6 loads `wdata` into the tag-staging register. A register read with index 6 returns that register. Register writes to any other index change nothing, and register reads of any other index return 0.
- R3: An insert write (space 1) stores `wdata` as the entry, and the staged tag as the tag, into the lowest-indexed slot whose entry has bit 63 clear.
- R4: When every slot is valid, an insert write replaces the lowest-indexed slot whose entry has bit 6 clear. Slots with bit 6 set keep their contents.
- R5: When every slot is both valid and locked, an insert write changes no slot, and `ovf` is 1 for exactly the one cycle after that write.
- R6: A slot write (space 2) stores `wdata` and the staged tag into the slot selected by `addr[8:3]`, whether that slot is locked or not. A slot read (space 2) returns the entry of the slot selected by `addr[8:3]`.
- R7: A lookup read (space 3) returns the tag of the lowest-indexed valid slot whose tag equals `addr`. A read result appears on `rdata` the cycle after the read, and `rdata` changes only after reads.
- R8: A lookup read that finds no valid slot with an equal tag returns 0. Invalid slots never match, whatever their stored tag.
- R9: The tag stored by a write is the value of the tag-staging register at the time of that write. Later loads of the staging register do not alter tags that are already stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Command valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| space | input | 2 | 0 register, 1 insert, 2 slot, 3 lookup |
| addr | input | 64 | Register/slot index in bits [8:3], or the lookup tag |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read result |
| ovf | output | 1 | One-cycle pulse: insert dropped because all slots are locked |

## Verification
Slot contents and the staging register change at the clock edge that ends a write. A read issued in the following cycle therefore already sees them, and its result lands on `rdata` one edge after the read. The same holds for `ovf`, which is registered and reports an insert one edge after it. The bench drives each command on a falling edge and samples results at the next falling edge, half a cycle after the edge that produced them. Slot choice is made visible by slot reads after each insert, including the all-locked drop and the eviction of a single unlocked slot.

// File: rtl/tlb_lock_cam.sv
module tlb_lock_cam #(
  parameter int ENTRIES = 64,
  parameter int W       = 64,
  parameter int VB      = 63,
  parameter int LB      = 6,
  parameter int RIW     = 4,
  parameter int TAGACC  = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         we,
  input  logic [1:0]   space,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         ovf
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [1:0] SP_REG = 2'd0, SP_INS = 2'd1, SP_SLOT = 2'd2, SP_LOOK = 2'd3;

  logic [W-1:0]  ent [ENTRIES];
  logic [W-1:0]  tag [ENTRIES];
  logic [W-1:0]  tag_acc;
  logic [IW-1:0] inv_idx, unl_idx;
  logic          inv_found, unl_found, hit_found;
  logic [W-1:0]  hit_tag;

  wire [IW-1:0]  slot    = addr[3 +: IW];
  wire [RIW-1:0] reg_idx = addr[3 +: RIW];
  wire           is_tacc = (reg_idx == RIW'(TAGACC));

  always_comb begin
    inv_found = 1'b0; inv_idx = '0;
    unl_found = 1'b0; unl_idx = '0;
    hit_found = 1'b0; hit_tag = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent[i][VB]) begin
        inv_found = 1'b1;
        inv_idx   = IW'(i);
      end
      if (!ent[i][LB]) begin
        unl_found = 1'b1;
        unl_idx   = IW'(i);
      end
      if (ent[i][VB] && tag[i] == addr) begin
        hit_found = 1'b1;
        hit_tag   = tag[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent[i] <= '0;
        tag[i] <= '0;
      end
      tag_acc <= '0;
    end else if (req && we) begin
      case (space)
        SP_REG:  if (is_tacc) tag_acc <= wdata;
        SP_INS: begin
          if (inv_found) begin
            ent[inv_idx] <= wdata;
            tag[inv_idx] <= tag_acc;
          end else if (unl_found) begin
            ent[unl_idx] <= wdata;
            tag[unl_idx] <= tag_acc;
          end
        end
        SP_SLOT: begin
          ent[slot] <= wdata;
          tag[slot] <= tag_acc;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= req && we && (space == SP_INS) && !inv_found && !unl_found;
      if (req && !we) begin
        case (space)
          SP_REG:  rdata <= is_tacc ? tag_acc : '0;
          SP_SLOT: rdata <= ent[slot];
          SP_LOOK: rdata <= hit_found ? hit_tag : '0;
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

module tlb_lock_cam_chk #(
  parameter int W  = 64,
  parameter int VB = 63,
  parameter int LB = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req,
  input logic         we,
  input logic [1:0]   space,
  input logic [W-1:0] addr,
  input logic [W-1:0] rdata,
  input logic         ovf,
  input logic [W-1:0] tag_acc,
  input logic [W-1:0] ent0
);
  AST_OVF_NEEDS_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(req && we && space == 2'd1)); // R5
  AST_RDATA_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req && !we) |-> $stable(rdata)); // R7
  AST_TAGACC_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req && we && space == 2'd0 && addr[6:3] == 4'd6) |-> $stable(tag_acc)); // R2
  AST_LOCKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req && we && space == 2'd1 && ent0[VB] && ent0[LB]) |-> $stable(ent0)); // R4
endmodule

bind tlb_lock_cam tlb_lock_cam_chk #(.W(W), .VB(VB), .LB(LB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .space(space), .addr(addr),
  .rdata(rdata), .ovf(ovf), .tag_acc(tag_acc), .ent0(ent[0])
);

// File: tb/tlb_lock_cam_bench.sv
module tlb_lock_cam_bench;
  logic        clk = 0, rst_n = 0, req = 0, we = 0;
  logic [1:0]  space = 0;
  logic [63:0] addr = 0, wdata = 0, rdata;
  logic        ovf;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tlb_lock_cam u_tlb_lock_cam (.clk, .rst_n, .req, .we, .space, .addr, .wdata, .rdata, .ovf);

  localparam logic [63:0] V = 64'h8000_0000_0000_0000, L = 64'h40;
  localparam logic [63:0] E1 = V | 64'h1000, E2 = V | 64'h2000, E3 = V | 64'h3000;
  // {we, space, addr, wdata, chk, exp}
  localparam int NV = 18;
  localparam logic [195:0] VEC [NV] = '{
    {1'b1, 2'd0, 64'h30, 64'hA1, 1'b0, 64'h0},   // R2 load tag
    {1'b0, 2'd0, 64'h30, 64'h0,  1'b1, 64'hA1},  // R2
    {1'b1, 2'd0, 64'h28, 64'hFF, 1'b0, 64'h0},   // R2 other index
    {1'b0, 2'd0, 64'h28, 64'h0,  1'b1, 64'h0},   // R2
    {1'b0, 2'd0, 64'h30, 64'h0,  1'b1, 64'hA1},  // R2
    {1'b1, 2'd1, 64'h0,  E1,     1'b0, 64'h0},   // R3 insert -> slot 0
    {1'b0, 2'd2, 64'h0,  64'h0,  1'b1, E1},      // R3
    {1'b0, 2'd3, 64'hA1, 64'h0,  1'b1, 64'hA1},  // R7
    {1'b0, 2'd3, 64'hB2, 64'h0,  1'b1, 64'h0},   // R8
    {1'b1, 2'd0, 64'h30, 64'hB2, 1'b0, 64'h0},
    {1'b1, 2'd1, 64'h0,  E2,     1'b0, 64'h0},   // R3 -> slot 1
    {1'b0, 2'd2, 64'h8,  64'h0,  1'b1, E2},      // R3
    {1'b1, 2'd0, 64'h30, 64'hC3, 1'b0, 64'h0},
    {1'b0, 2'd3, 64'hB2, 64'h0,  1'b1, 64'hB2},  // R9
    {1'b1, 2'd2, 64'h0,  64'h55, 1'b0, 64'h0},   // R6 invalidate slot 0
    {1'b0, 2'd3, 64'hA1, 64'h0,  1'b1, 64'h0},   // R8 invalid never matches
    {1'b1, 2'd1, 64'h0,  E3,     1'b0, 64'h0},   // R3 refill slot 0
    {1'b0, 2'd2, 64'h0,  64'h0,  1'b1, E3}       // R3
  };

  task automatic op(input logic w, input logic [1:0] s, input logic [63:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1; we = w; space = s; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
  endtask

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 0);
    chk("R1 ovf", {63'b0, ovf}, 0);
    rst_n = 1;
    op(0, 0, 64'h30, 0); chk("R1 tag reg", rdata, 0);
    op(0, 3, 64'h0, 0);  chk("R1 lookup", rdata, 0);
    for (int k = 0; k < NV; k++) begin
      logic [195:0] v = VEC[k];
      op(v[195], v[194:193], v[192:129], v[128:65]);
      if (v[64]) chk($sformatf("R2/R3/R6-R9 vec %0d", k), rdata, v[63:0]);
    end
    chk("R5 no ovf with free slot", {63'b0, ovf}, 0);
    op(1, 0, 64'h30, 64'hD4);
    for (int i = 0; i < 64; i++) op(1, 2, 64'(i) << 3, V | L | (64'(i) << 8));
    op(0, 2, 64'(5) << 3, 0); chk("R6 locked slot write", rdata, V | L | (64'd5 << 8));
    op(1, 1, 0, E1);
    chk("R5 ovf pulse", {63'b0, ovf}, 1);
    op(0, 2, 64'h0, 0);
    chk("R5 ovf cleared", {63'b0, ovf}, 0);
    chk("R5 slot 0 kept", rdata, V | L);
    op(1, 2, 64'(37) << 3, V | 64'h2500);
    op(1, 1, 0, E2);
    chk("R4 no ovf", {63'b0, ovf}, 0);
    op(0, 2, 64'(37) << 3, 0); chk("R4 unlocked replaced", rdata, E2);
    op(0, 2, 64'(36) << 3, 0); chk("R4 locked kept", rdata, V | L | (64'd36 << 8));
    op(0, 3, 64'hD4, 0); chk("R7 lookup hit", rdata, 64'hD4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule